// File: doc/BRIEF.md
# Flag-Tagged Temporary Register Unit

This block holds a small bank of temporary registers in which every entry carries its own set of arithmetic flags (zero, carry, sign, overflow) next to its data. Whenever an ALU result is written into a temporary, that temporary's flag set is replaced. Zero and sign are derived from the stored value at the operation size. Carry and overflow arrive from the ALU with the result. No global flags register exists in this path, and nothing here alters one.

A second port issues conditional and flag-maintenance operations. A conditional select, a conditional move and a conditional jump decision each test a condition code against the flags of their first source register. A flag copy transfers one temporary's flag set onto another. A flag insert loads a flag set from a 4-bit immediate. Select and move results leave on a result port. Jump decisions leave on a branch port as a taken bit and the chosen micro address.

Top module: `tagreg_cond_unit`

## Requirements
- R1: With `rst` high at a clock edge, `res_valid` and `br_valid` go low and every temporary's flag set is cleared (Z=C=S=O=0).
- R2: A write (`wr_en`) stores `wr_data` in temporary `wr_idx`. It stores the full 64 bits when `wr_wide`=1, and otherwise the low 32 bits zero-extended. It replaces that temporary's flags: Z is set when the stored value is zero, S is bit 63 (wide) or bit 31 (narrow) of `wr_data`, C is `wr_carry`, and O is `wr_ovf`.
- R3: Conditions test the flags of temporary `src_a`. `cond[2:1]` selects Z (0), C (1), S (2) or O (3), and `cond[0]`=1 negates the selected flag.
- R4: Select (`op_kind`=0) yields the data of `src_b` when the condition holds and zero otherwise.
- R5: Move (`op_kind`=1) yields the data of `src_a` when the condition holds and the data of `src_b` otherwise.
- R6: Jump (`op_kind`=2) raises `br_valid`. When the condition holds it drives `br_taken`=1 and `br_addr`=`jmp_target`; otherwise it drives `br_taken`=0 and `br_addr`=`jmp_next`.
- R7: Flag copy (`op_kind`=3) replaces the flag set of `dst` with the flag set of `src_a`. It leaves all data unchanged and produces no result or branch output.
- R8: Flag insert (`op_kind`=4) replaces the flag set of `dst` with `flag_imm` (bit 0 Z, bit 1 C, bit 2 S, bit 3 O). It leaves all data unchanged.
- R9: With `op_wide`=0, a select or move result keeps only its low 32 bits, and bits 63:32 of `res_data` are zero.
- R10: An operation issued in the same cycle as a write to one of its source temporaries sees the data and flags from before that write.
- R11: When a write and a flag copy or insert target the same temporary in the same cycle, the flag set from the write is kept.
- R12: A select, move or jump sampled at clock edge k shows its output valid after edge k+1 for exactly one cycle. `op_valid`=0, `op_kind` 3, 4, 5, 6 and 7 produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | ALU result write strobe |
| wr_idx | input | 4 | Destination temporary of the write |
| wr_data | input | 64 | ALU result |
| wr_wide | input | 1 | 1: 64-bit result, 0: 32-bit result |
| wr_carry | input | 1 | Carry produced by the ALU |
| wr_ovf | input | 1 | Overflow produced by the ALU |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 3 | 0 select, 1 move, 2 jump, 3 flag copy, 4 flag insert |
| op_wide | input | 1 | Result size for select and move |
| src_a | input | 4 | First source; its flags drive conditions |
| src_b | input | 4 | Second source |
| dst | input | 4 | Target temporary of flag copy or insert |
| cond | input | 3 | Condition code |
| flag_imm | input | 4 | Flag value for flag insert |
| jmp_target | input | 15 | Micro address taken when the jump condition holds |
| jmp_next | input | 15 | Micro address of the following step |
| res_valid | output | 1 | Select or move result valid |
| res_data | output | 64 | Select or move result |
| br_valid | output | 1 | Jump decision valid |
| br_taken | output | 1 | Jump condition held |
| br_addr | output | 15 | Next micro address |

## Verification
The properties assume that the operation fields are meaningful only while `op_valid` is high and that inputs are known from the first cycle after reset. They make no assumption about temporary data, because the data storage is not reset. Data read before it is written is therefore undefined. The stimulus writes every temporary before any select or move reads it. The only operations that use temporaries with no write behind them are jumps, which depend solely on the reset flag state. Random traffic keeps `op_kind` within 0 to 4, so that every issued operation has a defined expected outcome.

// File: rtl/tagreg_pkg.sv
package tagreg_pkg;

  typedef struct packed {
    logic o;
    logic s;
    logic c;
    logic z;
  } flags_t;

  typedef enum logic [2:0] {
    K_SEL   = 3'd0,
    K_CMOV  = 3'd1,
    K_JCC   = 3'd2,
    K_FCOPY = 3'd3,
    K_FINS  = 3'd4
  } op_kind_e;

endpackage

// File: rtl/tagreg_data_mem.sv
// Data storage: one write port, two synchronous read ports (read-before-write).
module tagreg_data_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/tagreg_flag_file.sv
// Per-temporary flag sets; ALU writes take priority over flag maintenance.
module tagreg_flag_file
  import tagreg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alu_we,
  input  logic [IW-1:0] alu_idx,
  input  flags_t        alu_flags,
  input  logic          fop_we,
  input  logic [IW-1:0] fop_idx,
  input  flags_t        fop_flags,
  input  logic [IW-1:0] rd_idx,
  output flags_t        cp_flags,
  output flags_t        rd_flags
);
  flags_t regs [DEPTH];

  assign cp_flags = regs[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      rd_flags <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alu_we && alu_idx == IW'(i))      regs[i] <= alu_flags;
        else if (fop_we && fop_idx == IW'(i)) regs[i] <= fop_flags;
      end
      rd_flags <= regs[rd_idx];
    end
  end
endmodule

// File: rtl/tagreg_cond_eval.sv
// Condition evaluation: cc[2:1] picks a flag, cc[0] negates it.
module tagreg_cond_eval
  import tagreg_pkg::*;
(
  input  flags_t     flg,
  input  logic [2:0] cc,
  output logic       hold
);
  logic raw;

  always_comb begin
    unique case (cc[2:1])
      2'd0: raw = flg.z;
      2'd1: raw = flg.c;
      2'd2: raw = flg.s;
      default: raw = flg.o;
    endcase
    hold = raw ^ cc[0];
  end
endmodule

// File: rtl/tagreg_cond_unit.sv
module tagreg_cond_unit
  import tagreg_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 64,
  parameter int NW   = 32,
  parameter int AW   = 15,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_wide,
  input  logic          wr_carry,
  input  logic          wr_ovf,
  input  logic          op_valid,
  input  logic [2:0]    op_kind,
  input  logic          op_wide,
  input  logic [IW-1:0] src_a,
  input  logic [IW-1:0] src_b,
  input  logic [IW-1:0] dst,
  input  logic [2:0]    cond,
  input  logic [3:0]    flag_imm,
  input  logic [AW-1:0] jmp_target,
  input  logic [AW-1:0] jmp_next,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          br_valid,
  output logic          br_taken,
  output logic [AW-1:0] br_addr
);
  // ---- write path: size truncation and flag derivation
  logic [DW-1:0] wr_store;
  flags_t        wr_flags;

  always_comb begin
    wr_store   = wr_wide ? wr_data : {{(DW-NW){1'b0}}, wr_data[NW-1:0]};
    wr_flags.z = (wr_store == '0);
    wr_flags.s = wr_wide ? wr_data[DW-1] : wr_data[NW-1];
    wr_flags.c = wr_carry;
    wr_flags.o = wr_ovf;
  end

  // ---- flag maintenance operations
  logic   fop_we;
  flags_t cp_flags, fop_flags, rd_flags;

  assign fop_we    = op_valid && (op_kind == K_FCOPY || op_kind == K_FINS);
  assign fop_flags = (op_kind == K_FCOPY) ? cp_flags : flags_t'(flag_imm);

  tagreg_data_mem #(.DEPTH(NREG), .DW(DW)) u_mem (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_idx),
    .wdata   (wr_store),
    .raddr_a (src_a),
    .raddr_b (src_b),
    .rdata_a (data_a),
    .rdata_b (data_b)
  );

  tagreg_flag_file #(.DEPTH(NREG)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .alu_we    (wr_en),
    .alu_idx   (wr_idx),
    .alu_flags (wr_flags),
    .fop_we    (fop_we),
    .fop_idx   (dst),
    .fop_flags (fop_flags),
    .rd_idx    (src_a),
    .cp_flags  (cp_flags),
    .rd_flags  (rd_flags)
  );

  // ---- stage 1: operation registered alongside the synchronous reads
  logic          s1_valid, s1_wide;
  logic [2:0]    s1_kind, s1_cc;
  logic [AW-1:0] s1_target, s1_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= op_valid && (op_kind == K_SEL || op_kind == K_CMOV || op_kind == K_JCC);
    end
    s1_kind   <= op_kind;
    s1_wide   <= op_wide;
    s1_cc     <= cond;
    s1_target <= jmp_target;
    s1_next   <= jmp_next;
  end

  // ---- stage 2: evaluate and register outputs
  logic          hold;
  logic [DW-1:0] pick, pick_sized;

  tagreg_cond_eval u_eval (
    .flg  (rd_flags),
    .cc   (s1_cc),
    .hold (hold)
  );

  always_comb begin
    if (s1_kind == K_SEL) pick = hold ? data_b : '0;
    else                  pick = hold ? data_a : data_b;
    pick_sized = s1_wide ? pick : {{(DW-NW){1'b0}}, pick[NW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      br_valid  <= 1'b0;
      br_taken  <= 1'b0;
      br_addr   <= '0;
    end else begin
      res_valid <= s1_valid && (s1_kind != K_JCC);
      br_valid  <= s1_valid && (s1_kind == K_JCC);
      if (s1_valid && s1_kind != K_JCC) res_data <= pick_sized;
      if (s1_valid && s1_kind == K_JCC) begin
        br_taken <= hold;
        br_addr  <= hold ? s1_target : s1_next;
      end
    end
  end

  logic [DW-1:0] data_a, data_b;
endmodule

// File: rtl/tagreg_cond_unit_chk.sv
module tagreg_cond_unit_chk #(
  parameter int DW = 64,
  parameter int NW = 32,
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [2:0]    op_kind,
  input logic          op_wide,
  input logic [AW-1:0] jmp_target,
  input logic [AW-1:0] jmp_next,
  input logic          res_valid,
  input logic [DW-1:0] res_data,
  input logic          br_valid,
  input logic [AW-1:0] br_addr
);
  // R12: every select, move or jump yields an output two edges later
  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind <= 3'd2) |-> ##2 (res_valid || br_valid));

  // R12: no operation, no output
  p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!op_valid) |-> ##2 (!res_valid && !br_valid));

  // R7: flag copy stays silent on the output ports
  p_copy_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd3) |-> ##2 (!res_valid && !br_valid));

  // R6: the jump address is one of the two supplied addresses
  p_jcc_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd2) |-> ##2
      (br_valid && (br_addr == $past(jmp_target, 2) || br_addr == $past(jmp_next, 2))));

  // R9: narrow results carry no upper bits
  p_narrow_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_wide && op_kind <= 3'd1) |-> ##2
      (res_valid && res_data[DW-1:NW] == '0));
endmodule

bind tagreg_cond_unit tagreg_cond_unit_chk #(.DW(DW), .NW(NW), .AW(AW)) u_chk (.*);

// File: tb/tagreg_cond_unit_bench.sv
module tagreg_cond_unit_bench;
  localparam int NREG = 16;
  localparam int DW   = 64;
  localparam int AW   = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 0, wr_wide = 0, wr_carry = 0, wr_ovf = 0;
  logic [3:0]    wr_idx = 0;
  logic [DW-1:0] wr_data = 0;
  logic          op_valid = 0, op_wide = 0;
  logic [2:0]    op_kind = 0, cond = 0;
  logic [3:0]    src_a = 0, src_b = 0, dst = 0, flag_imm = 0;
  logic [AW-1:0] jmp_target = 0, jmp_next = 0;
  logic          res_valid, br_valid, br_taken;
  logic [DW-1:0] res_data;
  logic [AW-1:0] br_addr;

  always #2 clk = ~clk;

  tagreg_cond_unit u_tagreg_cond_unit (.*);

  typedef struct {
    bit            is_br;
    logic [DW-1:0] data;
    bit            taken;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0, n_err = 0;

  // reference model: data, flags {O,S,C,Z}
  logic [DW-1:0] m_data [NREG];
  logic [3:0]    m_flags [NREG];
  bit            pw_en, pf_en;
  logic [3:0]    pw_idx, pf_idx, pw_flags, pf_val;
  logic [DW-1:0] pw_data;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic hold_f(input logic [3:0] f, input logic [2:0] cc);
    logic r;
    case (cc[2:1])
      2'd0: r = f[0];
      2'd1: r = f[1];
      2'd2: r = f[2];
      default: r = f[3];
    endcase
    return r ^ cc[0];
  endfunction

  task automatic set_write(input logic [3:0] idx, input logic [DW-1:0] d, input bit wide, input bit c, input bit o);
    logic [DW-1:0] st;
    st = wide ? d : {32'd0, d[31:0]};
    wr_en = 1; wr_idx = idx; wr_data = d; wr_wide = wide; wr_carry = c; wr_ovf = o;
    pw_en = 1; pw_idx = idx; pw_data = st;
    pw_flags = {o, (wide ? d[63] : d[31]), c, (st == 0)};
  endtask

  task automatic set_op(input logic [2:0] kind, input logic [3:0] a, input logic [3:0] b, input logic [3:0] d,
                        input logic [2:0] cc, input bit wide, input logic [3:0] imm,
                        input logic [AW-1:0] tgt, input logic [AW-1:0] nxt, input string tag);
    exp_t e;
    logic h;
    logic [DW-1:0] v;
    op_valid = 1; op_kind = kind; src_a = a; src_b = b; dst = d; cond = cc; op_wide = wide;
    flag_imm = imm; jmp_target = tgt; jmp_next = nxt;
    h = hold_f(m_flags[a], cc);
    e.tag = tag; e.is_br = 0; e.data = 0; e.taken = 0; e.addr = 0;
    if (kind == 3'd0 || kind == 3'd1) begin
      if (kind == 3'd0) v = h ? m_data[b] : '0;
      else              v = h ? m_data[a] : m_data[b];
      e.data = wide ? v : {32'd0, v[31:0]};
      q.push_back(e);
    end else if (kind == 3'd2) begin
      e.is_br = 1; e.taken = h; e.addr = h ? tgt : nxt;
      q.push_back(e);
    end else if (kind == 3'd3) begin
      pf_en = 1; pf_idx = d; pf_val = m_flags[a];
    end else if (kind == 3'd4) begin
      pf_en = 1; pf_idx = d; pf_val = imm;
    end
  endtask

  task automatic tick();
    if (pf_en) m_flags[pf_idx] = pf_val;
    if (pw_en) begin
      m_data[pw_idx]  = pw_data;
      m_flags[pw_idx] = pw_flags;
    end
    pf_en = 0; pw_en = 0;
    @(negedge clk);
    wr_en = 0; op_valid = 0;
  endtask

  task automatic drain();
    repeat (3) tick();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin : mon
    exp_t e;
    if (!rst && (res_valid || br_valid)) begin
      if (q.size() == 0) begin
        chk(0, "R12 unexpected output", {62'd0, res_valid, br_valid}, 0);
      end else begin
        e = q.pop_front();
        if (e.is_br)
          chk(br_valid && br_taken == e.taken && br_addr == e.addr, e.tag,
              {47'd0, br_valid, br_taken, br_addr}, {47'd0, 1'b1, e.taken, e.addr});
        else
          chk(res_valid && res_data == e.data, e.tag, res_data, e.data);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R12 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    pw_en = 0; pf_en = 0;
    for (int i = 0; i < NREG; i++) begin m_data[i] = 0; m_flags[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs low while in reset
    chk(!res_valid && !br_valid, "R1 reset outputs", {62'd0, res_valid, br_valid}, 0);
    rst = 0;
    @(negedge clk);

    // R1: flags cleared by reset, observed through jumps on an unwritten temporary
    set_op(3'd2, 4'd5, 4'd0, 4'd0, 3'd1, 1, 0, 15'h100, 15'h101, "R1 NZ after reset"); tick();
    set_op(3'd2, 4'd5, 4'd0, 4'd0, 3'd3, 1, 0, 15'h102, 15'h103, "R1 NC after reset"); tick();
    set_op(3'd2, 4'd5, 4'd0, 4'd0, 3'd4, 1, 0, 15'h104, 15'h105, "R1 S after reset"); tick();
    set_op(3'd2, 4'd5, 4'd0, 4'd0, 3'd6, 1, 0, 15'h106, 15'h107, "R1 O after reset"); tick();

    // R2: fill all temporaries, carry/overflow patterns from the index
    for (int i = 0; i < NREG; i++) begin
      set_write(4'(i), 64'(i) * 64'h0101_0101_0101_0101, 1, i[0], i[1]);
      tick();
    end

    // R3 R5: move under all eight codes, flags of temporary 0 (Z=1 only)
    for (int c = 0; c < 8; c++) begin
      set_op(3'd1, 4'd0, 4'd7, 4'd0, 3'(c), 1, 0, 0, 0, "R3 R5 move");
      tick();
    end
    // R3 R4: select under all eight codes, temporary 15 (C=1, O=1)
    for (int c = 0; c < 8; c++) begin
      set_op(3'd0, 4'd15, 4'd9, 4'd0, 3'(c), 1, 0, 0, 0, "R3 R4 select");
      tick();
    end
    // R6: jumps taken and not taken
    set_op(3'd2, 4'd3, 4'd0, 4'd0, 3'd2, 1, 0, 15'h7C00, 15'h0011, "R6 jump C taken"); tick();
    set_op(3'd2, 4'd2, 4'd0, 4'd0, 3'd2, 1, 0, 15'h7C00, 15'h0011, "R6 jump C not taken"); tick();

    // R2: narrow write drops upper half, Z from the 32-bit value
    set_write(4'd2, 64'hFFFF_FFFF_0000_0000, 0, 0, 0); tick();
    set_op(3'd1, 4'd2, 4'd3, 4'd0, 3'd0, 1, 0, 0, 0, "R2 narrow zero"); tick();
    set_write(4'd4, 64'h1234_5678_8000_0001, 0, 0, 0); tick();
    set_op(3'd2, 4'd4, 4'd0, 4'd0, 3'd4, 1, 0, 15'h0040, 15'h0041, "R2 narrow sign"); tick();
    set_op(3'd1, 4'd4, 4'd0, 4'd0, 3'd4, 1, 0, 0, 0, "R2 narrow data"); tick();

    // R9: narrow operation size
    set_op(3'd1, 4'd15, 4'd1, 4'd0, 3'd2, 0, 0, 0, 0, "R9 narrow move"); tick();
    set_op(3'd0, 4'd15, 4'd14, 4'd0, 3'd6, 0, 0, 0, 0, "R9 narrow select"); tick();

    // R8: insert S only into temporary 6
    set_op(3'd4, 4'd0, 4'd0, 4'd6, 3'd0, 1, 4'b0100, 0, 0, "R8 insert"); tick();
    set_op(3'd2, 4'd6, 4'd0, 4'd0, 3'd4, 1, 0, 15'h0200, 15'h0201, "R8 S set"); tick();
    set_op(3'd2, 4'd6, 4'd0, 4'd0, 3'd0, 1, 0, 15'h0202, 15'h0203, "R8 Z clear"); tick();
    set_op(3'd1, 4'd6, 4'd0, 4'd0, 3'd4, 1, 0, 0, 0, "R8 data kept"); tick();

    // R7: copy flags of temporary 0 onto temporary 8
    set_op(3'd3, 4'd0, 4'd0, 4'd8, 3'd0, 1, 0, 0, 0, "R7 copy"); tick();
    set_op(3'd2, 4'd8, 4'd0, 4'd0, 3'd0, 1, 0, 15'h0300, 15'h0301, "R7 Z copied"); tick();
    set_op(3'd1, 4'd8, 4'd1, 4'd0, 3'd0, 1, 0, 0, 0, "R7 data kept"); tick();

    // R10: same-cycle write and read of temporary 3
    set_write(4'd3, 64'd0, 1, 0, 0);
    set_op(3'd1, 4'd3, 4'd5, 4'd0, 3'd0, 1, 0, 0, 0, "R10 old value"); tick();
    set_op(3'd1, 4'd3, 4'd5, 4'd0, 3'd0, 1, 0, 0, 0, "R10 new value"); tick();

    // R11: write wins over insert on the same temporary
    set_write(4'd10, 64'h55, 1, 1, 0);
    set_op(3'd4, 4'd0, 4'd0, 4'd10, 3'd0, 1, 4'b0000, 0, 0, "R11 insert"); tick();
    set_op(3'd2, 4'd10, 4'd0, 4'd0, 3'd2, 1, 0, 15'h0400, 15'h0401, "R11 carry kept"); tick();
    drain();

    // R12: silent kinds and idle cycles
    set_op(3'd6, 4'd1, 4'd2, 4'd0, 3'd0, 1, 0, 0, 0, "R12"); tick(); tick();
    chk(!res_valid && !br_valid, "R12 kind 6 silent", {62'd0, res_valid, br_valid}, 0);
    set_op(3'd3, 4'd1, 4'd2, 4'd12, 3'd0, 1, 0, 0, 0, "R7"); tick(); tick();
    chk(!res_valid && !br_valid, "R7 copy silent", {62'd0, res_valid, br_valid}, 0);
    op_kind = 3'd0; tick(); tick();
    chk(!res_valid && !br_valid, "R12 idle silent", {62'd0, res_valid, br_valid}, 0);

    // R2 R3 R10 R11: random mixed traffic
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 2 == 0)
        set_write(4'($urandom), {$urandom, $urandom} & (($urandom % 4 == 0) ? 64'hFFFF_FFFF : '1),
                  1'($urandom), 1'($urandom), 1'($urandom));
      set_op(3'($urandom % 5), 4'($urandom), 4'($urandom), 4'($urandom), 3'($urandom),
             1'($urandom), 4'($urandom), 15'($urandom), 15'($urandom), "R2 R3 random");
      tick();
    end
    drain();
    chk(q.size() == 0, "R12 all outputs seen", 64'(q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule